// File: doc/BRIEF.md
# ASID-Tagged Unified TLB Lookup and Protection Check

This block is a fully associative translation buffer that maps 32-bit virtual addresses to physical addresses. Software loads entries one at a time through a write port, giving each a valid flag, a shared flag, an 8-bit address-space tag, a 22-bit virtual page number, a 22-bit physical page number, a 2-bit page-size field, a 2-bit protection field and a dirty flag. A single command clears the valid flag of every entry at once.

A lookup request carries a virtual address, an access kind, the current address-space tag, an enable for tag matching and a privileged-mode flag. The block compares the address against every entry in parallel, checks that exactly one entry matches, and then applies protection checks in a fixed order. One cycle after the request it returns a result code, the translated physical address and the read, write and execute grants.

Sequencing is a two-state machine. `ST_IDLE` holds while no request is present. A request in any state takes the transition *capture* into `ST_RESP`, where the registered result is presented with `rsp_valid` high. From `ST_RESP` the transition *retire* returns to `ST_IDLE` when no new request arrives, and *chain* stays in `ST_RESP` when one does.

Top module: `asid_tlb`

## Requirements
- R1: After reset `rsp_valid` is 0 and every entry is invalid, so any lookup gives a miss.
- R2: `rsp_valid` is 1 in exactly the cycle after each cycle with `req_valid` high, and 0 otherwise.
- R3: An entry whose valid flag is 0 never matches; `inv_all` clears every valid flag, and wins over a `wr_en` in the same cycle.
- R4: An entry with shared flag 0 is skipped when `asid_en` is 1 and its tag differs from `cur_asid`; a shared entry, or any entry when `asid_en` is 0, is compared by address only.
- R5: Page-size code 0, 1, 2, 3 selects 1 KB, 4 KB, 64 KB, 1 MB; an entry covers the aligned region that starts at `{vpn,10'b0}` with bits below the page size cleared, inclusive of both ends.
- R6: On a hit the physical address is `{ppn,10'b0}` with the in-page bits cleared, ORed with the in-page bits of the virtual address.
- R7: Access code 1 is a write, 2 an instruction fetch, 0 and 3 a read. With no match the code is 2 (miss on write) for a write and 1 (miss on read) otherwise.
- R8: With two or more matching entries the code is 3 (multiple match).
- R9: Unprivileged access to an entry with protection bit 1 clear gives code 4 for a read, 5 for a write, 7 for a fetch; this check comes first.
- R10: Otherwise a write to an entry with protection bit 0 clear gives code 5.
- R11: Otherwise a write to an entry with dirty flag 0 gives code 6 (first write to a clean page).
- R12: Otherwise the code is 0 (hit): a fetch is granted execute only; a data access is granted read, plus write only when protection bit 0 and the dirty flag are both set.
- R13: On any code other than 0 the physical address and all three grants are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Load one entry |
| wr_idx | input | 6 | Entry slot to load |
| wr_valid | input | 1 | Valid flag for the loaded entry |
| wr_shared | input | 1 | Shared flag (ignore tag) |
| wr_asid | input | 8 | Address-space tag |
| wr_vpn | input | 22 | Virtual page number (address bits 31:10) |
| wr_ppn | input | 22 | Physical page number |
| wr_size | input | 2 | Page-size code |
| wr_prot | input | 2 | Protection: bit 1 user access, bit 0 writable |
| wr_dirty | input | 1 | Dirty flag |
| inv_all | input | 1 | Clear every valid flag |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind |
| cur_asid | input | 8 | Current address-space tag |
| asid_en | input | 1 | Enable tag matching |
| priv | input | 1 | Privileged mode |
| rsp_valid | output | 1 | Result present |
| rsp_code | output | 3 | Result code |
| rsp_paddr | output | 32 | Physical address |
| rsp_grant_r | output | 1 | Read granted |
| rsp_grant_w | output | 1 | Write granted |
| rsp_grant_x | output | 1 | Execute granted |

## Verification
A corrupted entry field shows up at the ports in the very next response to an address inside that entry: a wrong size or page number moves the match boundary or the physical address, a wrong protection or dirty flag changes the code. A valid flag that survives invalidation turns an expected miss into a hit one cycle after the lookup. A stuck state register shows as `rsp_valid` present without a request, or missing after one, in the following cycle.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;
    localparam int VA_W   = 32;
    localparam int PG_LSB = 10;
    localparam int PN_W   = VA_W - PG_LSB;
    localparam int TAG_W  = 8;

    localparam logic [1:0] ACC_RD    = 2'd0;
    localparam logic [1:0] ACC_WR    = 2'd1;
    localparam logic [1:0] ACC_FETCH = 2'd2;

    typedef enum logic [2:0] {
        RC_HIT        = 3'd0,
        RC_MISS_RD    = 3'd1,
        RC_MISS_WR    = 3'd2,
        RC_MULTI      = 3'd3,
        RC_VIOL_RD    = 3'd4,
        RC_VIOL_WR    = 3'd5,
        RC_INIT_WR    = 3'd6,
        RC_VIOL_FETCH = 3'd7
    } tlb_rc_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } tlb_st_e;

    typedef struct packed {
        logic             v;
        logic             sh;
        logic [TAG_W-1:0] asid;
        logic [PN_W-1:0]  vpn;
        logic [PN_W-1:0]  ppn;
        logic [1:0]       sz;
        logic [1:0]       pr;
        logic             d;
    } tlb_ent_t;

    // Mask keeping the page-number bits for a given size code.
    function automatic logic [VA_W-1:0] page_mask(input logic [1:0] sz);
        logic [VA_W-1:0] m;
        unique case (sz)
            2'd0:    m = {VA_W{1'b1}} << 10;
            2'd1:    m = {VA_W{1'b1}} << 12;
            2'd2:    m = {VA_W{1'b1}} << 16;
            default: m = {VA_W{1'b1}} << 20;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
    import asid_tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  tlb_ent_t         wr_ent,
    input  logic             inv_all,
    output tlb_ent_t         ents [ENTRIES]
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) ents[i] <= '0;
        end else if (inv_all) begin
            for (int i = 0; i < ENTRIES; i++) ents[i].v <= 1'b0;
        end else if (wr_en) begin
            ents[wr_idx] <= wr_ent;
        end
    end
endmodule

// File: rtl/tlb_match.sv
module tlb_match
    import asid_tlb_pkg::*;
#(
    parameter int ENTRIES = 64
) (
    input  tlb_ent_t         ents [ENTRIES],
    input  logic [VA_W-1:0]  vaddr,
    input  logic [TAG_W-1:0] cur_asid,
    input  logic             asid_en,
    output logic             any_hit,
    output logic             multi,
    output logic [PN_W-1:0]  sel_ppn,
    output logic [1:0]       sel_sz,
    output logic [1:0]       sel_pr,
    output logic             sel_d
);
    logic [ENTRIES-1:0] hit;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        logic [VA_W-1:0] msk;
        logic            tag_ok;
        assign msk    = page_mask(ents[i].sz);
        assign tag_ok = ents[i].sh || !asid_en || (ents[i].asid == cur_asid);
        assign hit[i] = ents[i].v && tag_ok &&
                        ((vaddr & msk) == ({ents[i].vpn, {PG_LSB{1'b0}}} & msk));
    end

    assign any_hit = |hit;
    assign multi   = |(hit & (hit - 1'b1));

    always_comb begin
        sel_ppn = '0;
        sel_sz  = '0;
        sel_pr  = '0;
        sel_d   = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit[i]) begin
                sel_ppn = sel_ppn | ents[i].ppn;
                sel_sz  = sel_sz  | ents[i].sz;
                sel_pr  = sel_pr  | ents[i].pr;
                sel_d   = sel_d   | ents[i].d;
            end
        end
    end
endmodule

// File: rtl/tlb_perm.sv
module tlb_perm
    import asid_tlb_pkg::*;
(
    input  logic             any_hit,
    input  logic             multi,
    input  logic [PN_W-1:0]  ppn,
    input  logic [1:0]       sz,
    input  logic [1:0]       pr,
    input  logic             d,
    input  logic [VA_W-1:0]  vaddr,
    input  logic [1:0]       acc,
    input  logic             priv,
    output tlb_rc_e          code,
    output logic [VA_W-1:0]  paddr,
    output logic             g_r,
    output logic             g_w,
    output logic             g_x
);
    logic            is_wr, is_fetch, user_block;
    logic [VA_W-1:0] msk;

    assign is_wr      = (acc == ACC_WR);
    assign is_fetch   = (acc == ACC_FETCH);
    assign user_block = !priv && !pr[1];
    assign msk        = page_mask(sz);

    always_comb begin
        code  = RC_HIT;
        paddr = '0;
        g_r   = 1'b0;
        g_w   = 1'b0;
        g_x   = 1'b0;
        if (!any_hit) begin
            code = is_wr ? RC_MISS_WR : RC_MISS_RD;
        end else if (multi) begin
            code = RC_MULTI;
        end else if (is_fetch) begin
            if (user_block) begin
                code = RC_VIOL_FETCH;
            end else begin
                g_x   = 1'b1;
                paddr = ({ppn, {PG_LSB{1'b0}}} & msk) | (vaddr & ~msk);
            end
        end else if (user_block) begin
            code = is_wr ? RC_VIOL_WR : RC_VIOL_RD;
        end else if (is_wr && !pr[0]) begin
            code = RC_VIOL_WR;
        end else if (is_wr && !d) begin
            code = RC_INIT_WR;
        end else begin
            g_r   = 1'b1;
            g_w   = pr[0] && d;
            paddr = ({ppn, {PG_LSB{1'b0}}} & msk) | (vaddr & ~msk);
        end
    end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
    import asid_tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_valid,
    input  logic             wr_shared,
    input  logic [7:0]       wr_asid,
    input  logic [21:0]      wr_vpn,
    input  logic [21:0]      wr_ppn,
    input  logic [1:0]       wr_size,
    input  logic [1:0]       wr_prot,
    input  logic             wr_dirty,
    input  logic             inv_all,
    input  logic             req_valid,
    input  logic [31:0]      req_vaddr,
    input  logic [1:0]       req_acc,
    input  logic [7:0]       cur_asid,
    input  logic             asid_en,
    input  logic             priv,
    output logic             rsp_valid,
    output logic [2:0]       rsp_code,
    output logic [31:0]      rsp_paddr,
    output logic             rsp_grant_r,
    output logic             rsp_grant_w,
    output logic             rsp_grant_x
);
    tlb_ent_t        wr_ent;
    tlb_ent_t        ents [ENTRIES];
    logic            any_hit, multi, sel_d;
    logic [PN_W-1:0] sel_ppn;
    logic [1:0]      sel_sz, sel_pr;
    tlb_rc_e         c_code;
    logic [VA_W-1:0] c_paddr;
    logic            c_r, c_w, c_x;
    tlb_st_e         st_q, st_d;

    assign wr_ent = '{v: wr_valid, sh: wr_shared, asid: wr_asid, vpn: wr_vpn,
                      ppn: wr_ppn, sz: wr_size, pr: wr_prot, d: wr_dirty};

    tlb_entry_store #(.ENTRIES(ENTRIES)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_ent(wr_ent), .inv_all(inv_all), .ents(ents)
    );

    tlb_match #(.ENTRIES(ENTRIES)) u_match (
        .ents(ents), .vaddr(req_vaddr), .cur_asid(cur_asid), .asid_en(asid_en),
        .any_hit(any_hit), .multi(multi), .sel_ppn(sel_ppn), .sel_sz(sel_sz),
        .sel_pr(sel_pr), .sel_d(sel_d)
    );

    tlb_perm u_perm (
        .any_hit(any_hit), .multi(multi), .ppn(sel_ppn), .sz(sel_sz),
        .pr(sel_pr), .d(sel_d), .vaddr(req_vaddr), .acc(req_acc), .priv(priv),
        .code(c_code), .paddr(c_paddr), .g_r(c_r), .g_w(c_w), .g_x(c_x)
    );

    // Next state: capture / chain into ST_RESP, retire to ST_IDLE.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: st_d = req_valid ? ST_RESP : ST_IDLE;
            ST_RESP: st_d = req_valid ? ST_RESP : ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Result registers, loaded on every request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_code    <= RC_HIT;
            rsp_paddr   <= '0;
            rsp_grant_r <= 1'b0;
            rsp_grant_w <= 1'b0;
            rsp_grant_x <= 1'b0;
        end else if (req_valid) begin
            rsp_code    <= c_code;
            rsp_paddr   <= c_paddr;
            rsp_grant_r <= c_r;
            rsp_grant_w <= c_w;
            rsp_grant_x <= c_x;
        end
    end

    assign rsp_valid = (st_q == ST_RESP);
endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [1:0]  req_acc,
    input logic        inv_all,
    input logic        rsp_valid,
    input logic [2:0]  rsp_code,
    input logic [31:0] rsp_paddr,
    input logic        rsp_grant_r,
    input logic        rsp_grant_w,
    input logic        rsp_grant_x
);
    p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_no_rsp_without_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_inv_then_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(inv_all) && req_valid) |=> (rsp_code == 3'd1 || rsp_code == 3'd2));

    p_miss_wr_kind_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_acc == 2'd1) |=> (rsp_code != 3'd1 && rsp_code != 3'd4
                                            && rsp_code != 3'd7));

    p_fetch_grant_only_x_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_grant_x) |-> (!rsp_grant_r && !rsp_grant_w));

    p_write_implies_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_grant_w) |-> rsp_grant_r);

    p_fault_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code != 3'd0) |->
            (rsp_paddr == 32'd0 && !rsp_grant_r && !rsp_grant_w && !rsp_grant_x));
endmodule

bind asid_tlb asid_tlb_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_acc(req_acc),
    .inv_all(inv_all), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
    .rsp_paddr(rsp_paddr), .rsp_grant_r(rsp_grant_r),
    .rsp_grant_w(rsp_grant_w), .rsp_grant_x(rsp_grant_x)
);

// File: tb/asid_tlb_bench.sv
module asid_tlb_bench;
    localparam int N = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic        wr_valid = 1'b0, wr_shared = 1'b0, wr_dirty = 1'b0;
    logic [7:0]  wr_asid = '0;
    logic [21:0] wr_vpn = '0, wr_ppn = '0;
    logic [1:0]  wr_size = '0, wr_prot = '0;
    logic        inv_all = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic [7:0]  cur_asid = '0;
    logic        asid_en = 1'b0, priv = 1'b0;
    logic        rsp_valid, rsp_grant_r, rsp_grant_w, rsp_grant_x;
    logic [2:0]  rsp_code;
    logic [31:0] rsp_paddr;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // Bench copy of the table contents.
    logic        m_v [N];
    logic        m_sh [N];
    logic        m_d [N];
    logic [7:0]  m_asid [N];
    logic [21:0] m_vpn [N], m_ppn [N];
    logic [1:0]  m_sz [N], m_pr [N];

    always #2 clk = ~clk;

    asid_tlb u_asid_tlb (.*);

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] region_bytes(input logic [1:0] sz);
        case (sz)
            2'd0:    return 32'd1024;
            2'd1:    return 32'd4096;
            2'd2:    return 32'd65536;
            default: return 32'd1048576;
        endcase
    endfunction

    function automatic void model(input logic [31:0] a, input logic [1:0] acc,
                                  input logic [7:0] asid, input logic ae, input logic pv,
                                  output logic [2:0] code, output logic [31:0] pa,
                                  output logic gr, output logic gw, output logic gx);
        int cnt = 0;
        int k = 0;
        logic [31:0] sb, st, en;
        code = 3'd0; pa = '0; gr = 0; gw = 0; gx = 0;
        for (int i = 0; i < N; i++) begin
            if (!m_v[i]) continue;
            if (!m_sh[i] && ae && m_asid[i] != asid) continue;
            sb = region_bytes(m_sz[i]);
            st = {m_vpn[i], 10'b0} & ~(sb - 1);
            en = st + sb - 1;
            if (a >= st && a <= en) begin cnt++; k = i; end
        end
        if (cnt == 0) begin
            code = (acc == 2'd1) ? 3'd2 : 3'd1;
            return;
        end
        if (cnt > 1) begin code = 3'd3; return; end
        sb = region_bytes(m_sz[k]);
        if (acc == 2'd2) begin
            if (!pv && !m_pr[k][1]) begin code = 3'd7; return; end
            gx = 1;
        end else if (!pv && !m_pr[k][1]) begin
            code = (acc == 2'd1) ? 3'd5 : 3'd4; return;
        end else if (acc == 2'd1 && !m_pr[k][0]) begin
            code = 3'd5; return;
        end else if (acc == 2'd1 && !m_d[k]) begin
            code = 3'd6; return;
        end else begin
            gr = 1; gw = m_pr[k][0] & m_d[k];
        end
        pa = (({m_ppn[k], 10'b0}) & ~(sb - 1)) | (a & (sb - 1));
    endfunction

    task automatic load(input int idx, input logic v, input logic sh, input logic [7:0] asid,
                        input logic [21:0] vpn, input logic [21:0] ppn, input logic [1:0] sz,
                        input logic [1:0] pr, input logic d, input logic inv);
        @(negedge clk);
        wr_en = 1; wr_idx = idx[5:0]; wr_valid = v; wr_shared = sh; wr_asid = asid;
        wr_vpn = vpn; wr_ppn = ppn; wr_size = sz; wr_prot = pr; wr_dirty = d; inv_all = inv;
        @(negedge clk);
        wr_en = 0; inv_all = 0;
        if (inv) begin
            for (int i = 0; i < N; i++) m_v[i] = 0;
        end else begin
            m_v[idx] = v; m_sh[idx] = sh; m_asid[idx] = asid; m_vpn[idx] = vpn;
            m_ppn[idx] = ppn; m_sz[idx] = sz; m_pr[idx] = pr; m_d[idx] = d;
        end
    endtask

    task automatic lookup(input logic [31:0] a, input logic [1:0] acc, input logic [7:0] asid,
                          input logic ae, input logic pv, input string req);
        logic [2:0]  ec;
        logic [31:0] ep;
        logic        er, ew, ex;
        model(a, acc, asid, ae, pv, ec, ep, er, ew, ex);
        @(negedge clk);
        req_valid = 1; req_vaddr = a; req_acc = acc; cur_asid = asid; asid_en = ae; priv = pv;
        @(negedge clk);
        req_valid = 0;
        check(rsp_valid == 1'b1, "R2", "rsp_valid", 64'(rsp_valid), 64'd1);
        check(rsp_code == ec, req, "code", 64'(rsp_code), 64'(ec));
        check(rsp_paddr == ep && rsp_grant_r == er && rsp_grant_w == ew && rsp_grant_x == ex,
              req, "paddr/grants", {29'd0, rsp_grant_r, rsp_grant_w, rsp_grant_x, rsp_paddr},
              {29'd0, er, ew, ex, ep});
    endtask

    function automatic string tag_of(input logic [2:0] c);
        case (c)
            3'd0:          return "R12";
            3'd1, 3'd2:    return "R7";
            3'd3:          return "R8";
            3'd6:          return "R11";
            3'd5:          return "R10";
            default:       return "R9";
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_v[i] = 0; m_sh[i] = 0; m_d[i] = 0; m_asid[i] = 0;
            m_vpn[i] = 0; m_ppn[i] = 0; m_sz[i] = 0; m_pr[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        // R1: reset state
        check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
        lookup(32'h0004_0A34, 2'd0, 8'd0, 1'b0, 1'b1, "R1");
        // R6 / R12: 4 KB page, tag 5
        load(0, 1, 0, 8'd5, 22'h100, 22'h2000, 2'd1, 2'd3, 1, 0);
        lookup(32'h0004_0A34, 2'd0, 8'd5, 1'b1, 1'b0, "R6");
        check(rsp_paddr == 32'h0080_0A34, "R6", "fixed paddr", 64'(rsp_paddr), 64'h800A34);
        lookup(32'h0004_0FFF, 2'd1, 8'd5, 1'b1, 1'b0, "R12");
        lookup(32'h0004_0004, 2'd2, 8'd5, 1'b1, 1'b0, "R12");
        // R2: no request, no response
        @(negedge clk);
        check(rsp_valid == 1'b0, "R2", "idle rsp_valid", 64'(rsp_valid), 64'd0);
        // R4: tag matching
        lookup(32'h0004_0A34, 2'd0, 8'd6, 1'b1, 1'b1, "R4");
        lookup(32'h0004_0A34, 2'd0, 8'd6, 1'b0, 1'b1, "R4");
        load(1, 1, 1, 8'd9, 22'h400, 22'h55, 2'd0, 2'd2, 1, 0);
        lookup(32'h0010_03FF, 2'd0, 8'd2, 1'b1, 1'b0, "R4");
        lookup(32'h0010_0400, 2'd0, 8'd2, 1'b1, 1'b0, "R5");
        // R5: 1 MB and 64 KB boundaries
        load(2, 1, 1, 8'd0, 22'h1003, 22'h3_1234, 2'd3, 2'd3, 1, 0);
        lookup(32'h004F_FFFF, 2'd0, 8'd0, 1'b0, 1'b1, "R5");
        lookup(32'h0050_0000, 2'd0, 8'd0, 1'b0, 1'b1, "R5");
        lookup(32'h003F_FFFF, 2'd0, 8'd0, 1'b0, 1'b1, "R5");
        load(3, 1, 1, 8'd0, 22'h2040, 22'h0ABC, 2'd2, 2'd3, 1, 0);
        lookup(32'h0081_FFFF, 2'd0, 8'd0, 1'b0, 1'b1, "R5");
        lookup(32'h0082_0000, 2'd1, 8'd0, 1'b0, 1'b1, "R7");
        lookup(32'h0082_0000, 2'd3, 8'd0, 1'b0, 1'b1, "R7");
        // R8: overlapping entries
        load(4, 1, 1, 8'd0, 22'h101, 22'h77, 2'd0, 2'd3, 1, 0);
        lookup(32'h0004_0500, 2'd0, 8'd5, 1'b1, 1'b1, "R8");
        lookup(32'h0004_0000, 2'd0, 8'd5, 1'b1, 1'b1, "R8");
        // R9 / R10: protection
        load(5, 1, 1, 8'd0, 22'h800, 22'h7, 2'd0, 2'd0, 1, 0);
        lookup(32'h0020_0010, 2'd0, 8'd0, 1'b0, 1'b0, "R9");
        lookup(32'h0020_0010, 2'd1, 8'd0, 1'b0, 1'b0, "R9");
        lookup(32'h0020_0010, 2'd2, 8'd0, 1'b0, 1'b0, "R9");
        lookup(32'h0020_0010, 2'd0, 8'd0, 1'b0, 1'b1, "R12");
        lookup(32'h0020_0010, 2'd1, 8'd0, 1'b0, 1'b1, "R10");
        // R11: clean page
        load(6, 1, 1, 8'd0, 22'hC00, 22'h99, 2'd0, 2'd3, 0, 0);
        lookup(32'h0030_0020, 2'd1, 8'd0, 1'b0, 1'b1, "R11");
        check(rsp_code == 3'd6, "R11", "clean write code", 64'(rsp_code), 64'd6);
        lookup(32'h0030_0020, 2'd0, 8'd0, 1'b0, 1'b0, "R12");
        // R3: invalid entries, invalidate-all priority
        load(6, 0, 1, 8'd0, 22'hC00, 22'h99, 2'd0, 2'd3, 1, 0);
        lookup(32'h0030_0020, 2'd0, 8'd0, 1'b0, 1'b1, "R3");
        load(7, 1, 1, 8'd0, 22'h900, 22'h1, 2'd0, 2'd3, 1, 1);
        lookup(32'h0024_0000, 2'd0, 8'd0, 1'b0, 1'b1, "R3");
        lookup(32'h0004_0A34, 2'd0, 8'd5, 1'b1, 1'b1, "R3");
        check(rsp_code == 3'd1, "R3", "miss after invalidate", 64'(rsp_code), 64'd1);
        // Random phase
        void'($urandom(32'd1234));
        for (int i = 0; i < N; i++)
            load(i, ($urandom % 8) != 0, ($urandom % 4) == 0, 8'($urandom % 4 + 1),
                 22'($urandom % 256), 22'($urandom), 2'($urandom), 2'($urandom),
                 1'($urandom), 0);
        for (int j = 0; j < 400; j++) begin
            logic [31:0] a;
            logic [1:0]  acc;
            logic [2:0]  ec;
            logic [31:0] ep;
            logic        er, ew, ex;
            logic [7:0]  as;
            logic        ae, pv;
            a = $urandom % (256 * 1024);
            acc = 2'($urandom % 4);
            as = 8'($urandom % 4 + 1);
            ae = 1'($urandom);
            pv = 1'($urandom);
            model(a, acc, as, ae, pv, ec, ep, er, ew, ex);
            lookup(a, acc, as, ae, pv, tag_of(ec));
        end
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule